// File: doc/BRIEF.md
# Pulse-Gated Instruction Control Decoder

This block turns an 8-bit instruction word into the timed control strobes that a simple register-and-bus datapath needs for three instruction classes. The first class is a register-to-register move. The second is an ALU operation. The third is a load-immediate whose short signed field is widened to a full byte. Every control line is a decoded instruction field gated by one of three timing windows, C, D and E. A small step sequencer inside the block generates these windows.

The sequencer counts steps from 1 upward. When the word belongs to one of the three recognised classes, a short-instruction flag is raised during window D. The sequencer latches that flag and wraps back to step 1 after step 8. Otherwise it runs its full default length. The instruction word must be held stable from step 1 until the next return to step 1. The current step is visible on an output so that fetch logic can follow it.

Top module: `pulse_ctrl_dec`

## Requirements
- R1: While reset is low, `seq_step` is 1 and every strobe, select, function and immediate output is zero.
- R2: `seq_step` runs 1, 2, ... and wraps to 1 after step 12 by default. If the short-instruction flag was raised during the current instruction, it wraps to 1 after step 8 instead.
- R3: `pulse_c` is high in steps 3 to 6, `pulse_d` in steps 4 to 5, and `pulse_e` in steps 3 to 6.
- R4: A word of the form 00dddsss is a move. While `pulse_c` is high, bit sss of `drv_sel` is high and all other bits are low. The register codes are 0=A, 1=B, 2=C, 3=D, 4=M1, 5=M2, 6=X and 7=Y, and each code is also the bit index.
- R5: For a move, while `pulse_d` is high, bit ddd of `ld_sel` is high and all other bits are low. The load window therefore lies inside the source drive window.
- R6: A word of the form 1000rfff is an ALU operation. While `pulse_d` is high, `cond_ld` is high and `ld_sel` selects A (bit 0) when r=0 or D (bit 3) when r=1.
- R7: For an ALU operation, while `pulse_e` is high, `alu_oe` is high and `alu_fn` equals fff (000 NOP, 001 ADD, 010 INC, 011 AND, 100 OR, 101 XOR, 110 NOT, 111 SHL). At all other times `alu_fn` is 000.
- R8: A word of the form 01rvvvvv is a load-immediate. While `pulse_e` is high, `imm_oe` is high and `imm_val` equals vvvvv with bit 4 copied into bits 7:5, so 0x5F gives 0xFF and 0x6D gives 0x0D. At all other times `imm_val` is 0x00.
- R9: For a load-immediate, while `pulse_d` is high, `ld_sel` selects A (bit 0) when r=0 or B (bit 1) when r=1.
- R10: `abort8` is high exactly when `pulse_d` is high and the word is a move, an ALU operation or a load-immediate.
- R11: Words matching none of the three classes (1001xxxx, 101xxxxx, 11xxxxxx) assert no select, strobe, function or abort output, and the instruction runs the default 12 steps.
- R12: At most one bit of `drv_sel` and at most one bit of `ld_sel` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 8 | Instruction word, held from step 1 until the next step 1 |
| seq_step | output | 4 | Current sequencer step, starting at 1 |
| pulse_c | output | 1 | Timing window C |
| pulse_d | output | 1 | Timing window D |
| pulse_e | output | 1 | Timing window E |
| drv_sel | output | 8 | One-hot register bus-drive select |
| ld_sel | output | 8 | One-hot register load strobe |
| alu_fn | output | 3 | ALU function lines |
| alu_oe | output | 1 | ALU result drive onto the bus |
| cond_ld | output | 1 | Condition register load strobe |
| imm_oe | output | 1 | Immediate-to-bus enable |
| imm_val | output | 8 | Sign-extended immediate value |
| abort8 | output | 1 | Short-instruction flag toward the sequencer |

## Verification
The hardest state to reach from the ports is the end of a short instruction. There, the latched flag must be cleared at the wrap, so that an unrecognised word that follows runs the full twelve steps rather than inheriting the shortened length. The stimulus sends recognised and unrecognised words back to back in both orders. Every step of every instruction is checked against the expected step number, so a stale latch or a missing wrap shows up as a step mismatch. Move words that use the same register as source and destination, and the extreme immediate values -16, -1 and 15, are included.

// File: rtl/pulse_ctrl_dec.sv
module pulse_ctrl_dec #(
  parameter int DEF_STEPS   = 12,
  parameter int SHORT_STEPS = 8,
  parameter int C_FIRST = 3,
  parameter int C_LAST  = 6,
  parameter int D_FIRST = 4,
  parameter int D_LAST  = 5,
  parameter int E_FIRST = 3,
  parameter int E_LAST  = 6,
  localparam int STEP_W = $clog2(DEF_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        instr,
  output logic [STEP_W-1:0] seq_step,
  output logic              pulse_c,
  output logic              pulse_d,
  output logic              pulse_e,
  output logic [7:0]        drv_sel,
  output logic [7:0]        ld_sel,
  output logic [2:0]        alu_fn,
  output logic              alu_oe,
  output logic              cond_ld,
  output logic              imm_oe,
  output logic [7:0]        imm_val,
  output logic              abort8
);

  localparam logic [STEP_W-1:0] FIRST_STEP = STEP_W'(1);

  logic [STEP_W-1:0] step_q;
  logic              short_q;
  logic              wrap;
  logic              chat;

  wire is_mv  = (instr[7:6] == 2'b00);
  wire is_ldi = (instr[7:6] == 2'b01);
  wire is_alu = (instr[7:4] == 4'b1000);
  wire known  = is_mv | is_ldi | is_alu;

  assign seq_step = step_q;
  assign pulse_c  = (step_q >= STEP_W'(C_FIRST)) && (step_q <= STEP_W'(C_LAST));
  assign pulse_d  = (step_q >= STEP_W'(D_FIRST)) && (step_q <= STEP_W'(D_LAST));
  assign pulse_e  = (step_q >= STEP_W'(E_FIRST)) && (step_q <= STEP_W'(E_LAST));

  assign chat   = pulse_d;
  assign abort8 = chat & known;

  assign wrap = ((step_q == STEP_W'(SHORT_STEPS)) && short_q) ||
                (step_q == STEP_W'(DEF_STEPS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= FIRST_STEP;
      short_q <= 1'b0;
    end else begin
      step_q  <= wrap ? FIRST_STEP : step_q + FIRST_STEP;
      short_q <= wrap ? 1'b0 : (short_q | abort8);
    end
  end

  assign drv_sel = (is_mv && pulse_c) ? (8'b1 << instr[2:0]) : 8'b0;

  always_comb begin
    ld_sel = 8'b0;
    if (pulse_d) begin
      if (is_mv)
        ld_sel = 8'b1 << instr[5:3];
      else if (is_alu)
        ld_sel = instr[3] ? 8'b0000_1000 : 8'b0000_0001;
      else if (is_ldi)
        ld_sel = instr[5] ? 8'b0000_0010 : 8'b0000_0001;
    end
  end

  assign cond_ld = is_alu & pulse_d;
  assign alu_oe  = is_alu & pulse_e;
  assign alu_fn  = alu_oe ? instr[2:0] : 3'b000;
  assign imm_oe  = is_ldi & pulse_e;
  assign imm_val = imm_oe ? {{3{instr[4]}}, instr[4:0]} : 8'h00;

endmodule

// File: rtl/pulse_ctrl_dec_chk.sv
module pulse_ctrl_dec_chk #(
  parameter int STEP_W      = 4,
  parameter int DEF_STEPS   = 12,
  parameter int SHORT_STEPS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        instr,
  input logic [STEP_W-1:0] seq_step,
  input logic              short_q,
  input logic              pulse_c,
  input logic              pulse_d,
  input logic [7:0]        drv_sel,
  input logic [7:0]        ld_sel,
  input logic [2:0]        alu_fn,
  input logic              alu_oe,
  input logic              cond_ld,
  input logic              imm_oe,
  input logic [7:0]        imm_val,
  input logic              abort8
);

  AST_DRV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(drv_sel)); // R12
  AST_LD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ld_sel)); // R12
  AST_LD_IN_D: assert property (@(posedge clk) disable iff (!rst_n) (|ld_sel) |-> pulse_d); // R5
  AST_MV_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ld_sel) && instr[7:6] == 2'b00) |-> ((|drv_sel) && pulse_c)); // R4
  AST_COND_WITH_LD: assert property (@(posedge clk) disable iff (!rst_n) cond_ld |-> $onehot(ld_sel)); // R6
  AST_FN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !alu_oe |-> (alu_fn == 3'b000)); // R7
  AST_IMM_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !imm_oe |-> (imm_val == 8'h00)); // R8
  AST_ABORT_IN_D: assert property (@(posedge clk) disable iff (!rst_n) abort8 |-> pulse_d); // R10
  AST_SHORT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_step == STEP_W'(SHORT_STEPS) && short_q) |=> (seq_step == STEP_W'(1))); // R2
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_step >= STEP_W'(1)) && (seq_step <= STEP_W'(DEF_STEPS))); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_step != STEP_W'(DEF_STEPS) && seq_step != STEP_W'(SHORT_STEPS)) |=> (seq_step == $past(seq_step) + STEP_W'(1))); // R2

endmodule

bind pulse_ctrl_dec pulse_ctrl_dec_chk #(
  .STEP_W(STEP_W), .DEF_STEPS(DEF_STEPS), .SHORT_STEPS(SHORT_STEPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .seq_step(seq_step), .short_q(short_q),
  .pulse_c(pulse_c), .pulse_d(pulse_d), .drv_sel(drv_sel), .ld_sel(ld_sel),
  .alu_fn(alu_fn), .alu_oe(alu_oe), .cond_ld(cond_ld), .imm_oe(imm_oe),
  .imm_val(imm_val), .abort8(abort8)
);

// File: tb/test_pulse_ctrl_dec.sv
`timescale 1ns/1ps
module test_pulse_ctrl_dec;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] instr = 8'hFF;
  logic [3:0] seq_step;
  logic       pulse_c, pulse_d, pulse_e;
  logic [7:0] drv_sel, ld_sel, imm_val;
  logic [2:0] alu_fn;
  logic       alu_oe, cond_ld, imm_oe, abort8;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pulse_ctrl_dec i_pulse_ctrl_dec (
    .clk(clk), .rst_n(rst_n), .instr(instr), .seq_step(seq_step),
    .pulse_c(pulse_c), .pulse_d(pulse_d), .pulse_e(pulse_e),
    .drv_sel(drv_sel), .ld_sel(ld_sel), .alu_fn(alu_fn), .alu_oe(alu_oe),
    .cond_ld(cond_ld), .imm_oe(imm_oe), .imm_val(imm_val), .abort8(abort8)
  );

  typedef struct {
    logic [7:0] ins;
    logic [3:0] step;
    logic       pc, pd, pe;
    logic [7:0] drv, ld, imm;
    logic [2:0] fn;
    logic       aoe, cld, ioe, ab;
  } exp_t;

  exp_t q[$];

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp, input logic [3:0] st);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s step %0d %s: got %h expected %h", req, st, what, got, exp);
    end
  endtask

  task automatic run_instr(input logic [7:0] w);
    bit mv, alu, ldi, known;
    int len;
    do begin
      @(posedge clk);
      #1;
    end while (seq_step != 4'd1);
    instr = w;
    mv  = (w[7:6] == 2'b00);
    ldi = (w[7:6] == 2'b01);
    alu = (w[7:4] == 4'b1000);
    known = mv | ldi | alu;
    len = known ? 8 : 12;
    for (int s = 1; s <= len; s++) begin
      exp_t e;
      e.ins = w;
      e.step = 4'(s);
      e.pc = (s >= 3 && s <= 6);
      e.pd = (s >= 4 && s <= 5);
      e.pe = (s >= 3 && s <= 6);
      e.drv = (mv && e.pc) ? (8'b1 << w[2:0]) : 8'h00;
      e.ld = 8'h00;
      if (e.pd) begin
        if (mv) e.ld = 8'b1 << w[5:3];
        else if (alu) e.ld = w[3] ? 8'h08 : 8'h01;
        else if (ldi) e.ld = w[5] ? 8'h02 : 8'h01;
      end
      e.aoe = alu && e.pe;
      e.fn  = e.aoe ? w[2:0] : 3'b000;
      e.cld = alu && e.pd;
      e.ioe = ldi && e.pe;
      e.imm = e.ioe ? {w[4], w[4], w[4], w[4:0]} : 8'h00;
      e.ab  = known && e.pd;
      q.push_back(e);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        string rl, rf, rc, ri, ra, rd;
        e = q.pop_front();
        if (e.ins[7:6] == 2'b00) begin rl = "R5"; rd = "R4"; rf = "R7"; rc = "R6"; ri = "R8"; end
        else if (e.ins[7:6] == 2'b01) begin rl = "R9"; rd = "R4"; rf = "R7"; rc = "R6"; ri = "R8"; end
        else if (e.ins[7:4] == 4'b1000) begin rl = "R6"; rd = "R4"; rf = "R7"; rc = "R6"; ri = "R8"; end
        else begin rl = "R11"; rd = "R11"; rf = "R11"; rc = "R11"; ri = "R11"; end
        ra = (rl == "R11") ? "R11" : "R10";
        chk("R2", "seq_step", {4'b0, seq_step}, {4'b0, e.step}, e.step);
        chk("R3", "pulses", {5'b0, pulse_c, pulse_d, pulse_e}, {5'b0, e.pc, e.pd, e.pe}, e.step);
        chk(rd, "drv_sel", drv_sel, e.drv, e.step);
        chk(rl, "ld_sel", ld_sel, e.ld, e.step);
        chk(rf, "alu_fn/oe", {4'b0, alu_oe, alu_fn}, {4'b0, e.aoe, e.fn}, e.step);
        chk(rc, "cond_ld", {7'b0, cond_ld}, {7'b0, e.cld}, e.step);
        chk(ri, "imm_oe/val", imm_oe ? imm_val : 8'hEE, e.ioe ? e.imm : 8'hEE, e.step);
        chk(ri, "imm_val idle", imm_oe ? 8'h00 : imm_val, 8'h00, e.step);
        chk(ra, "abort8", {7'b0, abort8}, {7'b0, e.ab}, e.step);
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    instr = 8'h1A;
    repeat (3) @(negedge clk);
    // R1: reset state with a valid move word present
    chk("R1", "seq_step", {4'b0, seq_step}, 8'h01, seq_step);
    chk("R1", "strobes", {drv_sel | ld_sel | imm_val}, 8'h00, seq_step);
    chk("R1", "misc", {1'b0, pulse_c, pulse_d, pulse_e, alu_oe, cond_ld, imm_oe, abort8}, 8'h00, seq_step);
    chk("R1", "alu_fn", {5'b0, alu_fn}, 8'h00, seq_step);
    rst_n = 1'b1;

    run_instr(8'h1A);
    run_instr(8'h3C);
    run_instr(8'h00);
    run_instr(8'h3F);
    run_instr(8'h93);
    run_instr(8'h8B);
    run_instr(8'h82);
    run_instr(8'h80);
    run_instr(8'h8F);
    run_instr(8'hA5);
    run_instr(8'h5F);
    run_instr(8'h6D);
    run_instr(8'h70);
    run_instr(8'h4F);
    run_instr(8'hFF);
    run_instr(8'hC0);
    run_instr(8'h07);

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule